// File: doc/BRIEF.md
# Host-to-Slave Input Mailbox Channel

This block is the inbound half of a keyboard-controller-style host interface that sits between an external host bus and an embedded slave CPU. The block has two independent channels. On each channel the host drops a byte into an 8-bit input data register using that channel's active-low chip select, a shared active-low write strobe, a shared address line and the host data bus. Alongside the byte, the block keeps a command/data marker taken from the address line. It then sets an input-buffer-full flag for that channel.

The write strobe comes from the host and is asynchronous to the system clock. It passes through a two-flop synchronizer. The rising edge of the synchronized strobe produces a one-cycle capture pulse. A channel whose chip select is low at that pulse takes the byte. For this to work, the host holds chip select, the address line and the data stable for at least three system clocks after the strobe rises.

The slave sees the block through a small register port. Each channel has a data address and a status address, and one control address holds the interrupt enables. When a channel's byte is waiting and its enable is set, the block drives a level interrupt to the slave. Reading the data address empties the buffer, which also drops the interrupt.

Top module: `kbd_inbox`

## Requirements
- R1: After reset every full flag is 0, every command/data bit is 0, every interrupt enable is 0 and both interrupt outputs are 0. Reading any status address or the control address returns 0.
- R2: A channel captures `host_data` only on the rising edge of `host_wr_n`, and only if that channel's `host_cs_n` bit is low. The captured value is visible on the slave port after the third rising clock edge that follows the strobe's rise. A strobe with chip select high leaves that channel unchanged, and so does a chip select with no strobe rise.
- R3: Each capture copies `host_a0` into the channel's command/data bit, which is status bit 3 (1 = command, 0 = data).
- R4: Each capture sets the channel's full flag, which is status bit 1. A capture while the flag is already set replaces the data byte and the command/data bit, and the flag stays set.
- R5: A slave read (`slv_rd` high) of a channel's data address clears that channel's full flag at the next clock edge. Reading the status address leaves the flag unchanged. If a capture and a data read land on the same edge, the capture wins: the flag stays set and the new byte is held.
- R6: `irq[i]` is high exactly while channel i's full flag and channel i's enable are both 1.
- R7: The control register sits at address 4. Bit i is channel i's interrupt enable. It is written by `slv_wr` and read back with all other bits reading 0.
- R8: Channel i's data is at address 2*i and its status at address 2*i+1. Status bits other than 1 and 3 read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 2 | Per-channel host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low; capture on its rise |
| host_a0 | input | 1 | Host address bit, 1 = command, 0 = data |
| host_data | input | 8 | Host write data bus |
| slv_addr | input | 3 | Slave register address |
| slv_rd | input | 1 | Slave read strobe; a data-address read empties the channel |
| slv_wr | input | 1 | Slave write strobe to the control register |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data for `slv_addr`, combinational |
| irq | output | 2 | Per-channel input-buffer-full interrupt, level |

## Verification
Suppose the synchronizer has a wrong stage count or a wrong edge polarity. The data byte and the full flag would then appear on the slave port one edge early, one edge late, or on the wrong edge of the strobe. A reference model that follows the strobe clock by clock catches this at the third edge after the strobe rises. A corrupted full flag, command/data bit or enable shows up at once on `irq` and on the next status or control read. Because the bench compares every clock, a wrong clear priority on the coincident write-and-read edge is caught in the very cycle it occurs.

// File: rtl/kbd_inbox_pkg.sv
package kbd_inbox_pkg;
    localparam int DATA_W   = 8;
    localparam int FULL_BIT = 1;
    localparam int CMD_BIT  = 3;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              cmd;
    } chan_state_t;
endpackage

// File: rtl/kbd_inbox_sync.sv
module kbd_inbox_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {W{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R2: a strobe rise gives exactly one capture pulse
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/kbd_inbox_chan.sv
module kbd_inbox_chan
    import kbd_inbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise_i,
    input  logic              cs_n_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              rd_clr_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              cmd_o,
    output logic              irq_o
);
    chan_state_t st_d, st_q;
    logic        cap;

    assign cap = wr_rise_i & ~cs_n_i;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.data = din_i;
            st_d.cmd  = a0_i;
            st_d.full = 1'b1;
        end else if (rd_clr_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;
    assign cmd_o  = st_q.cmd;
    assign irq_o  = st_q.full & en_i;

    p_fill_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> st_q.full);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !cap) |=> !st_q.full);
    p_cmd_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (st_q.cmd == $past(a0_i)));
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(st_q.data));
endmodule

// File: rtl/kbd_inbox.sv
module kbd_inbox
    import kbd_inbox_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int AW     = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    host_cs_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_data,
    input  logic [AW-1:0]     slv_addr,
    input  logic              slv_rd,
    input  logic              slv_wr,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic [DATA_W-1:0] slv_rdata,
    output logic [NCH-1:0]    irq
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(2 * NCH);

    logic              wr_rise;
    logic [NCH-1:0]    ctrl_d, ctrl_q;
    logic [DATA_W-1:0] ch_data [NCH];
    logic [NCH-1:0]    ch_full, ch_cmd;
    logic              unused_wdata;

    assign unused_wdata = ^slv_wdata;

    kbd_inbox_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_wr_n),
        .rise_o  (wr_rise)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic rd_clr;
        assign rd_clr = slv_rd && (slv_addr == AW'(2 * g));
        kbd_inbox_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_rise_i (wr_rise),
            .cs_n_i    (host_cs_n[g]),
            .a0_i      (host_a0),
            .din_i     (host_data),
            .rd_clr_i  (rd_clr),
            .en_i      (ctrl_q[g]),
            .data_o    (ch_data[g]),
            .full_o    (ch_full[g]),
            .cmd_o     (ch_cmd[g]),
            .irq_o     (irq[g])
        );
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (slv_wr && slv_addr == CTRL_ADDR) ctrl_d = slv_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        slv_rdata = '0;
        if (slv_addr == CTRL_ADDR) slv_rdata = DATA_W'(ctrl_q);
        for (int i = 0; i < NCH; i++) begin
            if (slv_addr == AW'(2 * i)) begin
                slv_rdata = ch_data[i];
            end else if (slv_addr == AW'(2 * i + 1)) begin
                slv_rdata[FULL_BIT] = ch_full[i];
                slv_rdata[CMD_BIT]  = ch_cmd[i];
            end
        end
    end

    // R7: enables change only through a control-address write
    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_wr && slv_addr == CTRL_ADDR) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_kbd_inbox.sv
module sim_kbd_inbox;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] host_cs_n = 2'b11;
    logic       host_wr_n = 1;
    logic       host_a0 = 0;
    logic [7:0] host_data = 0;
    logic [2:0] slv_addr = 0;
    logic       slv_rd = 0;
    logic       slv_wr = 0;
    logic [7:0] slv_wdata = 0;
    logic [7:0] slv_rdata;
    logic [1:0] irq;

    int    n_vec = 0;
    int    n_bad = 0;
    string req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    kbd_inbox u0 (.*);

    // behavioural reference model
    int m_data[2];
    bit m_wr[2], m_full[2], m_cmd[2], m_en[2];
    bit s1 = 1, s2 = 1, s3 = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_full[c] = 0; m_cmd[c] = 0; m_en[c] = 0; m_wr[c] = 0;
            end
            s1 = 1; s2 = 1; s3 = 1;
        end else begin
            bit pulse;
            pulse = s2 && !s3;
            for (int c = 0; c < 2; c++) begin
                if (pulse && !host_cs_n[c]) begin
                    m_data[c] = int'(host_data); m_cmd[c] = host_a0;
                    m_full[c] = 1; m_wr[c] = 1;
                end else if (slv_rd && int'(slv_addr) == 2 * c) begin
                    m_full[c] = 0;
                end
            end
            if (slv_wr && slv_addr == 3'd4) begin
                m_en[0] = slv_wdata[0]; m_en[1] = slv_wdata[1];
            end
            s3 = s2; s2 = s1; s1 = host_wr_n;
        end
    end

    task automatic step();
        int a, exp_rd, exp_irq;
        bit known;
        @(negedge clk);
        a = int'(slv_addr);
        known = 1;
        exp_rd = 0;
        case (a)
            0, 2: begin exp_rd = m_data[a/2]; known = m_wr[a/2]; end
            1, 3: exp_rd = (int'(m_full[a/2]) << 1) | (int'(m_cmd[a/2]) << 3);
            4:    exp_rd = int'(m_en[0]) | (int'(m_en[1]) << 1);
            default: exp_rd = 0;
        endcase
        exp_irq = int'(m_full[0] && m_en[0]) | (int'(m_full[1] && m_en[1]) << 1);
        if (known) begin
            n_vec++;
            if (int'(slv_rdata) != exp_rd) begin
                n_bad++;
                $display("FAIL %s addr=%0d rdata actual=%02h expected=%02h", req, a, slv_rdata, exp_rd);
            end
        end
        n_vec++;
        if (int'(irq) != exp_irq) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp_irq);
        end
    endtask

    task automatic host_write(input logic [1:0] cs, input logic a0, input logic [7:0] d);
        host_cs_n = cs; host_a0 = a0; host_data = d; host_wr_n = 0;
        step(); step();
        host_wr_n = 1;
        for (int k = 0; k < 4; k++) step();
        host_cs_n = 2'b11;
        step();
    endtask

    task automatic sread(input int a);
        slv_addr = 3'(a); slv_rd = 1;
        step();
        slv_rd = 0;
        step();
    endtask

    task automatic swrite(input int a, input logic [7:0] d);
        slv_addr = 3'(a); slv_wr = 1; slv_wdata = d;
        step();
        slv_wr = 0;
        step();
    endtask

    task automatic scan();
        for (int a = 0; a < 8; a++) begin
            slv_addr = 3'(a);
            step();
        end
    endtask

    initial begin
        logic [7:0] lf;
        // R1: reset state
        req = "R1";
        step(); step();
        rst_n = 1;
        step();
        scan();
        // R2 R3 R4: command byte into channel 0, channel 1 untouched
        req = "R2";
        slv_addr = 3'd1;
        host_write(2'b10, 1'b1, 8'hA5);
        scan();
        req = "R3";
        host_write(2'b01, 1'b0, 8'h3C);
        scan();
        // R7 R6: enables and interrupt level
        req = "R7";
        swrite(4, 8'hFD);
        scan();
        req = "R6";
        swrite(4, 8'h03);
        scan();
        // R4: overwrite while full
        req = "R4";
        host_write(2'b10, 1'b0, 8'h5A);
        scan();
        // R5: status read keeps flag, data read clears it
        req = "R5";
        sread(1);
        sread(0);
        scan();
        // R5: capture and data read on the same edge
        host_cs_n = 2'b01; host_a0 = 1; host_data = 8'hE7; host_wr_n = 0;
        step(); step();
        host_wr_n = 1;
        step(); step();
        slv_addr = 3'd2; slv_rd = 1;
        step();
        slv_rd = 0;
        step(); step();
        host_cs_n = 2'b11;
        scan();
        // R2: strobe with chip selects high, chip select without strobe
        req = "R2";
        sread(0); sread(2);
        host_write(2'b11, 1'b1, 8'h11);
        host_cs_n = 2'b00; host_data = 8'h22;
        for (int k = 0; k < 6; k++) step();
        host_cs_n = 2'b11;
        scan();
        // R8: map and unused bits
        req = "R8";
        swrite(4, 8'h00);
        scan();
        // mixed traffic
        req = "R4";
        lf = 8'h9B;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (lf[1:0])
                2'd0: host_write({~lf[2], lf[2]}, lf[3], lf);
                2'd1: sread(int'(lf[4:2]));
                2'd2: swrite(4, lf);
                default: host_write({lf[5], lf[4]}, lf[6], ~lf);
            endcase
            scan();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule